// File: doc/BRIEF.md
# Latched Interrupt Status Controller

This block gathers up to 32 interrupt sources from a peripheral and drives one combined interrupt line toward a processor. Each implemented source has a latched status bit and an enable bit. A single global enable gates the combined output. Level-type and pulse-type sources are both sampled every cycle, and any high source sets its status bit. That bit holds until software acknowledges it.

Software reaches the block through a simple word-addressed register port. The status register toggles on write. A one written over a clear bit sets it, which supports self-test. A one written over a set bit clears it, which is the acknowledge. A zero changes nothing. Implemented bits sit at the top of the 32-bit word and count down from bit 31. Deciding which source to service first is left to software.

Register map, by word address:
- 0: status
- 1: enable
- 2: global enable, held in bit 31
- 3: always reads zero

Top module: `irq_latch_ctrl`

## Requirements
- R1: Parameter NUM_BITS (0 to 32) sets the number of implemented bits. These occupy bit positions 31 down to 32-NUM_BITS. NUM_BITS = 0 leaves no status or enable bits.
- R2: Unimplemented bit positions read as zero in the status and enable registers. This holds whatever the sources or writes do at those positions.
- R3: The enable register and the global enable bit reset to zero.
- R4: The status register has no fixed reset value. While reset is asserted it loads the implemented sources, so a source that is high through reset reads as set right after reset.
- R5: A write to address 0 acts per bit. A 1 over a clear status bit sets it, a 1 over a set bit clears it, and a 0 leaves the bit unchanged.
- R6: Once a source sets a status bit, the bit stays set after the source falls, until software acknowledges it.
- R7: A source that is high in the same cycle as an acknowledging write wins, and the bit stays set. A level source still asserted keeps its bit set through the acknowledge.
- R8: irq_out is high exactly when (status AND enable) is non-zero and the global enable is set. It reflects a register change from the cycle after the write or source edge.
- R9: Global enable is written and read at address 2, bit 31. All other bits of that word read zero.
- R10: A read asserts rvalid with rdata one cycle after rd_en. Reads have no side effects. Address 3 reads zero.
- R11: A write to address 1 replaces the enable register with the write data, restricted to the implemented bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src | input | 32 | Interrupt sources, MSB-aligned with the status bits |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Word address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid with rvalid |
| rvalid | output | 1 | High one cycle after rd_en |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The assertions assume the sources and strobes are known, non-X values from the first clock edge. They also assume each strobe is held for exactly one clock edge. The stimulus meets this by driving every input on the falling edge and holding it for one full period. Write and read strobes never overlap, so a read never sees the same-cycle write that the toggle checks would otherwise have to model. Sources stay stable across each edge, so pulse events are whole cycles that the status bank samples once.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int REG_W   = 32;
  localparam int ADDR_W  = 2;
  localparam int GIE_BIT = REG_W - 1;

  localparam logic [ADDR_W-1:0] A_STATUS = 2'd0;
  localparam logic [ADDR_W-1:0] A_ENABLE = 2'd1;
  localparam logic [ADDR_W-1:0] A_GLOBAL = 2'd2;

  // Bits implemented from the MSB downward
  function automatic logic [REG_W-1:0] impl_mask(input int n);
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < REG_W; i++) begin
      if (i >= REG_W - n) m[i] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank
  import irq_pkg::*;
#(
  parameter int NUM_BITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] src,
  input  logic             ack_wr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] status
);
  localparam logic [REG_W-1:0] MASK = impl_mask(NUM_BITS);

  logic unused_bits;
  assign unused_bits = ^{src & ~MASK, wdata & ~MASK};

  for (genvar i = 0; i < REG_W; i++) begin : g_bit
    if (i >= REG_W - NUM_BITS) begin : g_impl
      logic st_q;
      always_ff @(posedge clk) begin
        if (!rst_n)                 st_q <= src[i];
        else if (src[i])            st_q <= 1'b1;
        else if (ack_wr && wdata[i]) st_q <= ~st_q;
      end
      assign status[i] = st_q;

      AST_SRC_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        src[i] |=> st_q);  // R7
      AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q && !(ack_wr && wdata[i])) |=> st_q);  // R6
      AST_TOGGLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q && ack_wr && wdata[i] && !src[i]) |=> !st_q);  // R5
      AST_ZERO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q && !src[i] && !(ack_wr && wdata[i])) |=> !st_q);  // R5
    end else begin : g_none
      assign status[i] = 1'b0;
    end
  end
endmodule

// File: rtl/irq_enable_bank.sv
module irq_enable_bank
  import irq_pkg::*;
#(
  parameter int NUM_BITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_wr,
  input  logic             gie_wr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] enable,
  output logic             gie
);
  localparam logic [REG_W-1:0] MASK = impl_mask(NUM_BITS);

  logic [REG_W-1:0] en_q;
  logic             gie_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= '0;
      gie_q <= 1'b0;
    end else begin
      if (en_wr)  en_q  <= wdata & MASK;
      if (gie_wr) gie_q <= wdata[GIE_BIT];
    end
  end

  assign enable = en_q;
  assign gie    = gie_q;

  AST_EN_IMPL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q & ~MASK) == '0);  // R2
  AST_EN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en_wr |=> $stable(en_q));  // R11
  AST_GIE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !gie_wr |=> $stable(gie_q));  // R9
endmodule

// File: rtl/irq_read_port.sv
module irq_read_port
  import irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  status,
  input  logic [REG_W-1:0]  enable,
  input  logic              gie,
  output logic [REG_W-1:0]  rdata,
  output logic              rvalid
);
  logic [REG_W-1:0] sel;
  logic [REG_W-1:0] rdata_q;
  logic             rvalid_q;

  always_comb begin
    sel = '0;
    unique case (addr)
      A_STATUS: sel = status;
      A_ENABLE: sel = enable;
      A_GLOBAL: sel[GIE_BIT] = gie;
      default:  sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_en;
      if (rd_en) rdata_q <= sel;
    end
  end

  assign rdata  = rdata_q;
  assign rvalid = rvalid_q;

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rvalid_q);  // R10
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rvalid_q);  // R10
endmodule

// File: rtl/irq_latch_ctrl.sv
module irq_latch_ctrl
  import irq_pkg::*;
#(
  parameter int NUM_BITS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_W-1:0]  src,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output logic              rvalid,
  output logic              irq_out
);
  localparam logic [REG_W-1:0] MASK = impl_mask(NUM_BITS);

  logic [REG_W-1:0] status;
  logic [REG_W-1:0] enable;
  logic [REG_W-1:0] pending;
  logic             gie;
  logic             ack_wr, en_wr, gie_wr;

  assign ack_wr = wr_en && (addr == A_STATUS);
  assign en_wr  = wr_en && (addr == A_ENABLE);
  assign gie_wr = wr_en && (addr == A_GLOBAL);

  irq_status_bank #(.NUM_BITS(NUM_BITS)) u_status (
    .clk(clk), .rst_n(rst_n), .src(src), .ack_wr(ack_wr),
    .wdata(wdata), .status(status)
  );

  irq_enable_bank #(.NUM_BITS(NUM_BITS)) u_enable (
    .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .gie_wr(gie_wr),
    .wdata(wdata), .enable(enable), .gie(gie)
  );

  irq_read_port u_read (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr),
    .status(status), .enable(enable), .gie(gie),
    .rdata(rdata), .rvalid(rvalid)
  );

  assign pending = status & enable;
  assign irq_out = (|pending) && gie;

  AST_IRQ_NEEDS_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> gie);  // R8
  AST_STATUS_IMPL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (status & ~MASK) == '0);  // R2
  AST_ENABLE_FROM_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (enable == '0 && !gie));  // R3
endmodule

// File: tb/irq_latch_ctrl_test.sv
module irq_latch_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid;
  logic        irq_out;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  irq_latch_ctrl #(.NUM_BITS(8)) uut (
    .clk(clk), .rst_n(rst_n), .src(src), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid),
    .irq_out(irq_out)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  // Driver: issue read, push expected result into the scoreboard
  task automatic rd(input logic [1:0] a, input logic [31:0] e, input string tag);
    rd_en = 1'b1; addr = a;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // Monitor: pop and compare each returned read
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (exp_q.size() == 0) begin
        check("R10 unexpected rvalid", 32'h1, 32'h0);
      end else begin
        check(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    // R4: sources high during reset appear in status; bit 0 is unimplemented (R2)
    src = 32'h8100_0001;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    src = '0;
    check("R3 irq_out after reset", {31'b0, irq_out}, 32'h0);
    rd(2'd0, 32'h8100_0000, "R4 status loaded from sources, R2 bit0 zero");
    rd(2'd1, 32'h0, "R3 enable reset value");
    rd(2'd2, 32'h0, "R3 R9 global reset value");
    // R5 acknowledge by writing ones over set bits
    wr(2'd0, 32'h8100_0000);
    rd(2'd0, 32'h0, "R5 ack clears");
    wr(2'd0, 32'h4000_0000);
    rd(2'd0, 32'h4000_0000, "R5 one over clear sets");
    wr(2'd0, 32'h0);
    rd(2'd0, 32'h4000_0000, "R5 zero write unchanged");
    wr(2'd0, 32'h0000_00FF);
    rd(2'd0, 32'h4000_0000, "R2 unimplemented write ignored");
    // R6 pulse source is sticky
    src = 32'h0200_0000;
    @(negedge clk);
    src = '0;
    rd(2'd0, 32'h4200_0000, "R6 pulse latched");
    rd(2'd0, 32'h4200_0000, "R10 read has no side effect");
    // R11 enable write, R8 gating
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, 32'hFF00_0000, "R11 R2 enable implemented bits only");
    check("R8 irq off while global clear", {31'b0, irq_out}, 32'h0);
    wr(2'd2, 32'hFFFF_FFFF);
    check("R8 irq on after global set", {31'b0, irq_out}, 32'h1);
    rd(2'd2, 32'h8000_0000, "R9 global only bit31");
    rd(2'd3, 32'h0, "R10 address 3 reads zero");
    wr(2'd1, 32'h0);
    check("R8 irq off after enable clear", {31'b0, irq_out}, 32'h0);
    wr(2'd1, 32'h0200_0000);
    check("R8 irq on single enabled pending bit", {31'b0, irq_out}, 32'h1);
    wr(2'd2, 32'h0);
    check("R8 irq off after global clear", {31'b0, irq_out}, 32'h0);
    // R7 level source still asserted wins over acknowledge
    src = 32'h1000_0000;
    @(negedge clk);
    wr(2'd0, 32'h1000_0000);
    rd(2'd0, 32'h5200_0000, "R7 held level source survives ack");
    src = '0;
    wr(2'd0, 32'h1000_0000);
    rd(2'd0, 32'h4200_0000, "R7 ack after source released clears");
    wr(2'd0, 32'h4200_0000);
    rd(2'd0, 32'h0, "R5 bulk ack clears all");
    // R1: all eight implemented top bits can be set by self-test write
    wr(2'd0, 32'hFF00_0000);
    rd(2'd0, 32'hFF00_0000, "R1 top eight bits implemented");
    repeat (3) @(negedge clk);
    check("R10 scoreboard drained", exp_q.size(), 32'h0);
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule